// File: doc/BRIEF.md
# Paged Address Translator

This block turns a byte-granular effective address into a wider actual address for the memory system. When the mode input is low, the effective address passes straight through with zero extension. When the mode input is high, the top bits of the address (the page number) select an entry in a page table. The entry replaces the page number with a real page number, and the offset bits within the page pass through unchanged.

Each virtual page also has an access code in a second table. In virtual mode that code is always checked against the kind of access, and a disallowed access raises a trap flag together with a cause. Both tables are loaded through simple write ports, one entry per clock. A lookup is purely combinational from the request inputs, so a CPU pipeline can use the result in the same cycle it presents the address.

Top module: `vaddr_xlate`

## Requirements
- R1: With `virt_mode` low, `act_addr` equals `req_addr` with three leading zero bits, and `trap` stays low whatever access code the page has.
- R2: With `virt_mode` high and no trap, `act_addr[21:11]` equals the stored real page number for page `req_addr[18:11]`, and `act_addr[10:0]` equals `req_addr[10:0]`.
- R3: A write with `map_we` high stores `map_data` in entry `map_idx` at the clock edge. The lookup returns it from the next cycle on, and all other entries keep their values.
- R4: After reset every page-table entry and every access code is zero, so a virtual lookup of any page gives real page 0 with no trap.
- R5: Access code 2'b00 allows both reads and writes: `trap` low and `trap_cause` 2'b00.
- R6: Access code 2'b01 allows reads (no trap). A write (`req_write` high) raises `trap` with `trap_cause` 2'b01.
- R7: Access codes 2'b10 and 2'b11 deny every access: `trap` high and `trap_cause` 2'b10 for both reads and writes.
- R8: `trap`, `trap_cause` and `act_addr` follow the request inputs in the same cycle, with no clock edge in between.
- R9: A write with `prot_we` high stores `prot_data` as the access code of page `prot_idx` at the clock edge, and the new code applies from the next cycle.
- R10: The 8-bit loaded value fills the low bits of the 11-bit real page number, so `act_addr[21:19]` is always zero when no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table write ports |
| rst_n | input | 1 | Asynchronous active-low reset, clears both tables |
| virt_mode | input | 1 | 1 = paged translation, 0 = pass-through |
| req_addr | input | 19 | Effective byte address of the access |
| req_write | input | 1 | 1 = write access, 0 = read access |
| map_we | input | 1 | Page-table write enable |
| map_idx | input | 8 | Page-table entry to write |
| map_data | input | 8 | Real page number value to load |
| prot_we | input | 1 | Access-code table write enable |
| prot_idx | input | 8 | Page whose access code is written |
| prot_data | input | 2 | Access code to load |
| act_addr | output | 22 | Actual byte address (undefined while trap is high) |
| trap | output | 1 | Access not permitted |
| trap_cause | output | 2 | 00 none, 01 write to read-only page, 10 no access |

## Verification
The bench builds the block with its default widths: a 19-bit address, an 8-bit page index, 8-bit loaded entries and an 11-bit real page number. This gives the full 256-entry table, including the top page 0xFF. Loading 0xFF there drives the highest loadable address bit, which shows that the three padding bits stay zero. The same widths also expose the 11-bit offset boundary between the translated and untranslated parts of the address.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   localparam int PROT_W = 2;

   typedef enum logic [1:0] {
      CAUSE_NONE      = 2'b00,
      CAUSE_WRITE_RO  = 2'b01,
      CAUSE_NO_ACCESS = 2'b10
   } trap_cause_e;

   localparam logic [PROT_W-1:0] PROT_RW = 2'b00;
   localparam logic [PROT_W-1:0] PROT_RO = 2'b01;
endpackage

// File: rtl/entry_table.sv
module entry_table #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("entry_table: widths must be positive");
   end

   logic [DATA_W-1:0] ent_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else if (we) begin
         ent_q[wr_idx] <= wr_data;
      end
   end

   assign rd_data = ent_q[rd_idx];

   // R3 / R9: a write lands in the addressed entry
   p_entry_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ent_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/prot_check.sv
module prot_check
   import xlate_pkg::*;
(
   input  logic              enable,
   input  logic              is_write,
   input  logic [PROT_W-1:0] code,
   output logic              trap,
   output trap_cause_e       cause
);
   always_comb begin
      cause = CAUSE_NONE;
      if (enable) begin
         if (code[1])                        cause = CAUSE_NO_ACCESS;
         else if (code == PROT_RO && is_write) cause = CAUSE_WRITE_RO;
      end
   end

   assign trap = (cause != CAUSE_NONE);
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
   import xlate_pkg::*;
#(
   parameter int EA_W   = 19,
   parameter int IDX_W  = 8,
   parameter int LOAD_W = 8,
   parameter int RPN_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              virt_mode,
   input  logic [EA_W-1:0]   req_addr,
   input  logic              req_write,
   input  logic              map_we,
   input  logic [IDX_W-1:0]  map_idx,
   input  logic [LOAD_W-1:0] map_data,
   input  logic              prot_we,
   input  logic [IDX_W-1:0]  prot_idx,
   input  logic [PROT_W-1:0] prot_data,
   output logic [RPN_W+EA_W-IDX_W-1:0] act_addr,
   output logic              trap,
   output logic [1:0]        trap_cause
);
   localparam int OFF_W = EA_W - IDX_W;
   localparam int ACT_W = RPN_W + OFF_W;
   localparam int PAD_W = ACT_W - EA_W;

   if (OFF_W < 1) begin : g_bad_off
      $error("vaddr_xlate: page index must be narrower than the address");
   end
   if (RPN_W < LOAD_W || RPN_W < IDX_W) begin : g_bad_rpn
      $error("vaddr_xlate: real page number too narrow");
   end

   logic [IDX_W-1:0]  page;
   logic [OFF_W-1:0]  offset;
   logic [LOAD_W-1:0] loaded;
   logic [RPN_W-1:0]  rpn;
   logic [PROT_W-1:0] code;
   trap_cause_e       cause;

   assign page   = req_addr[EA_W-1 -: IDX_W];
   assign offset = req_addr[OFF_W-1:0];

   entry_table #(.IDX_W(IDX_W), .DATA_W(LOAD_W)) u_map (
      .clk(clk), .rst_n(rst_n), .we(map_we), .wr_idx(map_idx),
      .wr_data(map_data), .rd_idx(page), .rd_data(loaded));

   entry_table #(.IDX_W(IDX_W), .DATA_W(PROT_W)) u_prot (
      .clk(clk), .rst_n(rst_n), .we(prot_we), .wr_idx(prot_idx),
      .wr_data(prot_data), .rd_idx(page), .rd_data(code));

   prot_check u_chk (
      .enable(virt_mode), .is_write(req_write), .code(code),
      .trap(trap), .cause(cause));

   if (RPN_W > LOAD_W) begin : g_pad_rpn
      assign rpn = {{(RPN_W-LOAD_W){1'b0}}, loaded};
      // R10: padding bits of the page number never reach the output
      p_high_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !trap |-> act_addr[ACT_W-1 -: RPN_W-LOAD_W] == '0);
   end else begin : g_full_rpn
      assign rpn = loaded;
   end

   always_comb begin
      if (virt_mode) act_addr = {rpn, offset};
      else           act_addr = {{PAD_W{1'b0}}, req_addr};
   end

   assign trap_cause = cause;

   // R1: pass-through mode never traps and keeps the address
   p_real_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !virt_mode |-> !trap && act_addr[EA_W-1:0] == req_addr);
   // R2: offset bits survive translation
   p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (virt_mode && !trap) |-> act_addr[OFF_W-1:0] == req_addr[OFF_W-1:0]);
   // R6: write to a read-only page traps with the write cause
   p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (virt_mode && code == PROT_RO && req_write) |-> trap && trap_cause == 2'b01);
   // R7: no-access codes always trap
   p_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (virt_mode && code[1]) |-> trap && trap_cause == 2'b10);
endmodule

// File: tb/tb_vaddr_xlate.sv
module tb_vaddr_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        virt_mode = 1'b0;
   logic [18:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        map_we = 1'b0;
   logic [7:0]  map_idx = '0;
   logic [7:0]  map_data = '0;
   logic        prot_we = 1'b0;
   logic [7:0]  prot_idx = '0;
   logic [1:0]  prot_data = '0;
   logic [21:0] act_addr;
   logic        trap;
   logic [1:0]  trap_cause;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   vaddr_xlate dut (
      .clk(clk), .rst_n(rst_n), .virt_mode(virt_mode), .req_addr(req_addr),
      .req_write(req_write), .map_we(map_we), .map_idx(map_idx),
      .map_data(map_data), .prot_we(prot_we), .prot_idx(prot_idx),
      .prot_data(prot_data), .act_addr(act_addr), .trap(trap),
      .trap_cause(trap_cause));

   typedef struct packed {
      logic        virt;
      logic        wr;
      logic [18:0] addr;
      logic [21:0] act;
      logic        trp;
      logic [1:0]  cause;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 19'h7FFFF, 22'h07FFFF, 1'b0, 2'b00},  // R1
      '{1'b0, 1'b1, 19'h1A123, 22'h01A123, 1'b0, 2'b00},  // R1 page 0x34 no-access ignored
      '{1'b1, 1'b0, 19'h09456, 22'h055C56, 1'b0, 2'b00},  // R2 R6 read ok
      '{1'b1, 1'b1, 19'h09456, 22'h000000, 1'b1, 2'b01},  // R6 write trap
      '{1'b1, 1'b0, 19'h1A000, 22'h000000, 1'b1, 2'b10},  // R7 code 10 read
      '{1'b1, 1'b1, 19'h1A800, 22'h000000, 1'b1, 2'b10},  // R7 code 11 write
      '{1'b1, 1'b1, 19'h7FFFF, 22'h07FFFF, 1'b0, 2'b00},  // R5 R10
      '{1'b1, 1'b0, 19'h00001, 22'h02D001, 1'b0, 2'b00},  // R2
      '{1'b1, 1'b1, 19'h00800, 22'h000000, 1'b0, 2'b00}   // R3 neighbour untouched
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_map(logic [7:0] idx, logic [7:0] val);
      @(negedge clk);
      map_we = 1'b1; map_idx = idx; map_data = val;
      @(negedge clk);
      map_we = 1'b0;
   endtask

   task automatic load_prot(logic [7:0] idx, logic [1:0] val);
      @(negedge clk);
      prot_we = 1'b1; prot_idx = idx; prot_data = val;
      @(negedge clk);
      prot_we = 1'b0;
   endtask

   task automatic ask(logic v, logic w, logic [18:0] a);
      virt_mode = v; req_write = w; req_addr = a;
      #1;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reset contents
      ask(1'b1, 1'b1, 19'h7FFFF);
      chk("R4 act", 32'(act_addr), 32'h0007FF);
      chk("R4 trap", 32'(trap), 32'h0);
      ask(1'b1, 1'b0, 19'h12345);
      chk("R4 act2", 32'(act_addr), 32'h000345);

      load_map(8'h12, 8'hAB);
      load_map(8'hFF, 8'hFF);
      load_map(8'h00, 8'h5A);
      load_prot(8'h12, 2'b01);
      load_prot(8'h34, 2'b10);
      load_prot(8'h35, 2'b11);

      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         ask(VEC[i].virt, VEC[i].wr, VEC[i].addr);
         chk($sformatf("R1-vector%0d trap", i), 32'(trap), 32'(VEC[i].trp));
         chk($sformatf("R6 R7 vector%0d cause", i), 32'(trap_cause), 32'(VEC[i].cause));
         if (!VEC[i].trp) begin
            chk($sformatf("R2 vector%0d act", i), 32'(act_addr), 32'(VEC[i].act));
            chk($sformatf("R10 vector%0d pad", i), 32'(act_addr[21:19]), 32'h0);
         end
      end

      // R8: same-cycle response, no edge between request changes
      @(negedge clk);
      ask(1'b1, 1'b1, 19'h09000);
      chk("R8 trap now", 32'(trap), 32'h1);
      ask(1'b1, 1'b0, 19'h09000);
      chk("R8 trap gone", 32'(trap), 32'h0);
      chk("R8 act", 32'(act_addr), 32'h055800);

      // R3: back-to-back loads on consecutive cycles
      @(negedge clk);
      map_we = 1'b1; map_idx = 8'h40; map_data = 8'h11;
      ask(1'b1, 1'b0, 19'h20000);
      chk("R3 not before edge", 32'(act_addr), 32'h000000);
      @(negedge clk);
      map_idx = 8'h41; map_data = 8'h22;
      #1;
      chk("R3 first load", 32'(act_addr), 32'h008800);
      @(negedge clk);
      map_we = 1'b0;
      ask(1'b1, 1'b0, 19'h20805);
      chk("R3 second load", 32'(act_addr), 32'h011005);
      ask(1'b1, 1'b0, 19'h20000);
      chk("R3 first kept", 32'(act_addr), 32'h008800);

      // R9: access code update takes effect next cycle
      load_prot(8'h12, 2'b00);
      ask(1'b1, 1'b1, 19'h09456);
      chk("R9 trap cleared", 32'(trap), 32'h0);
      chk("R5 act", 32'(act_addr), 32'h055C56);
      load_prot(8'h00, 2'b11);
      ask(1'b1, 1'b0, 19'h00001);
      chk("R9 cause set", 32'(trap_cause), 32'h2);
      ask(1'b0, 1'b0, 19'h00001);
      chk("R1 real ignores code", 32'(trap), 32'h0);
      chk("R1 real act", 32'(act_addr), 32'h000001);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule